// File: doc/BRIEF.md
# Page Translation Lookup

This block turns an address-space id and a virtual page number into a real page number, four permission/status flags and a fault bit. Before it touches any storage, it sorts each request onto one of four paths. An id of all ones maps the page to itself. A page inside the bypass window gets a computed real page. A page inside the shared window is looked up under id 0. Every other page is looked up under the request's own id. Each page covers 4 KB. Virtual and real page numbers are 22 bits wide, and the id is 16 bits wide.

Translations are held in a direct-mapped store of 256 entries. The store index is a fold-and-XOR hash of the id and the page. Each entry holds a page tag, an id, a real page, four flags and a valid bit. Entries are filled or flushed through a separate write port. The window mask/pattern pairs and the bypass base are plain configuration inputs and are assumed to be steady while requests are in flight.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. The block holds one result register. A request is taken on a clock edge when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. If the consumer holds `rsp_ready` low, the block stops accepting new requests and keeps the pending result unchanged.

Top module: `pgxlate_top`

## Requirements
- R1: A request is accepted on an edge where req_valid and req_ready are both high. rsp_valid is high in the cycle after acceptance. req_ready equals (not rsp_valid) or rsp_ready.
- R2: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_rp, rsp_flags and rsp_fault stay unchanged.
- R3: A request whose id is 16'hFFFF returns rsp_rp equal to the request page, rsp_flags = 4'b1100 and no fault. The flag bits are bit3 dirty, bit2 kernel write allowed, bit1 user write allowed, bit0 user read allowed.
- R4: Otherwise, a page with (vp & byp_mask) == byp_pat returns rsp_rp = (byp_base & byp_mask) | (vp & ~byp_mask), flags 4'b1100 and no fault, whatever the store holds. This path takes precedence over the shared window.
- R5: Otherwise, a page with (vp & shr_mask) == shr_pat is looked up with id 0 in place of the request id.
- R6: A lookup that finds a valid entry whose stored id and page equal the effective id and the request page returns the stored real page and flags with rsp_fault = 0.
- R7: A lookup that finds no such entry returns rsp_fault = 1 with rsp_rp = 0 and rsp_flags = 0.
- R8: The entry index bit k is the XOR of every bit j of the 38-bit key {id, vp} (vp in bits 21:0) with j mod 8 = k. A write to an index replaces the entry held there.
- R9: A write with wr_entry_valid = 0 flushes its entry, so later lookups of that key fault.
- R10: Writes with id 16'hFFFF, or with a page inside the bypass window, change no entry.
- R11: Reset empties the store and the result register. Writes presented while reset is high are dropped.
- R12: A lookup accepted in the same cycle as a write to its entry sees the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_id | input | 16 | Request address-space id |
| req_vp | input | 22 | Request virtual page |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_rp | output | 22 | Real page (0 on fault) |
| rsp_flags | output | 4 | Flags {dirty, kwrite, uwrite, uread} (0 on fault) |
| rsp_fault | output | 1 | Map fault: no matching entry |
| wr_en | input | 1 | Write strobe |
| wr_id | input | 16 | Id of written entry |
| wr_vp | input | 22 | Virtual page of written entry |
| wr_rp | input | 22 | Real page to store |
| wr_flags | input | 4 | Flags to store |
| wr_entry_valid | input | 1 | 1 fills, 0 flushes the entry |
| cfg_shr_pat | input | 22 | Shared window pattern |
| cfg_shr_mask | input | 22 | Shared window mask |
| cfg_byp_pat | input | 22 | Bypass window pattern |
| cfg_byp_mask | input | 22 | Bypass window mask |
| cfg_byp_base | input | 22 | Bypass base page |

## Verification
The assertions check the stream rules on every cycle: ready versus a pending result, a result one cycle after acceptance, and a result frozen while stalled. They also check the table-free paths, identity and bypass, which never fault and always carry the fixed flags, and that a faulting result carries zero data. Whether a lookup hits depends on the store's contents, so the bench's reference model is needed to show several behaviours. These are correct shared-id substitution, hash collisions evicting one another, flushes, dropped writes, writes during reset, and reads colliding with a same-cycle write.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int ID_W   = 16;
  localparam int VP_W   = 22;
  localparam int RP_W   = 22;
  localparam int FLAG_W = 4;
  localparam int KEY_W  = ID_W + VP_W;

  // {dirty, kernel write, user write, user read}
  localparam logic [FLAG_W-1:0] FIXED_FLAGS = 4'b1100;

  typedef enum logic [1:0] {
    PATH_IDENT  = 2'd0,
    PATH_BYPASS = 2'd1,
    PATH_SHARED = 2'd2,
    PATH_NORMAL = 2'd3
  } path_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [VP_W-1:0]   vp;
    logic [RP_W-1:0]   rp;
    logic [FLAG_W-1:0] flags;
  } entry_t;
endpackage

// File: rtl/pgx_hash.sv
module pgx_hash
  import pgx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [ID_W-1:0]  id,
  input  logic [VP_W-1:0]  vp,
  output logic [IDX_W-1:0] idx
);
  localparam int NCH   = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] key;
  logic [IDX_W-1:0] acc [NCH+1];

  assign key    = PAD_W'({id, vp});
  assign acc[0] = '0;

  for (genvar g = 0; g < NCH; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ key[g*IDX_W +: IDX_W];
  end

  assign idx = acc[NCH];
endmodule

// File: rtl/pgx_area_sel.sv
module pgx_area_sel
  import pgx_pkg::*;
(
  input  logic [ID_W-1:0] id,
  input  logic [VP_W-1:0] vp,
  input  logic [VP_W-1:0] shr_pat,
  input  logic [VP_W-1:0] shr_mask,
  input  logic [VP_W-1:0] byp_pat,
  input  logic [VP_W-1:0] byp_mask,
  input  logic [RP_W-1:0] byp_base,
  output path_e           path,
  output logic [ID_W-1:0] eff_id,
  output logic [RP_W-1:0] byp_rp
);
  logic is_ident, in_byp, in_shr;

  assign is_ident = &id;
  assign in_byp   = (vp & byp_mask) == byp_pat;
  assign in_shr   = (vp & shr_mask) == shr_pat;
  assign byp_rp   = (byp_base & byp_mask) | (vp & ~byp_mask);

  always_comb begin
    if (is_ident)    path = PATH_IDENT;
    else if (in_byp) path = PATH_BYPASS;
    else if (in_shr) path = PATH_SHARED;
    else             path = PATH_NORMAL;
  end

  assign eff_id = (path == PATH_SHARED) ? '0 : id;
endmodule

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output entry_t           rd_entry,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic             wr_vld
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] vld;

  // valid bits: cleared by reset, read before any same-edge write
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (rd_en) rd_vld <= vld[rd_idx];
      if (wr_en) vld[wr_idx] <= wr_vld;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (rd_en) rd_entry <= mem[rd_idx];
    if (wr_en) mem[wr_idx] <= wr_entry;
  end
endmodule

// File: rtl/pgxlate_top.sv
module pgxlate_top
  import pgx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [VP_W-1:0]   req_vp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RP_W-1:0]   rsp_rp,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              rsp_fault,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [VP_W-1:0]   wr_vp,
  input  logic [RP_W-1:0]   wr_rp,
  input  logic [FLAG_W-1:0] wr_flags,
  input  logic              wr_entry_valid,
  input  logic [VP_W-1:0]   cfg_shr_pat,
  input  logic [VP_W-1:0]   cfg_shr_mask,
  input  logic [VP_W-1:0]   cfg_byp_pat,
  input  logic [VP_W-1:0]   cfg_byp_mask,
  input  logic [RP_W-1:0]   cfg_byp_base
);
  // request side classification
  path_e            r_path;
  logic [ID_W-1:0]  r_eff_id;
  logic [RP_W-1:0]  r_byp_rp;
  logic [IDX_W-1:0] r_idx;

  pgx_area_sel u_req_sel (
    .id(req_id), .vp(req_vp),
    .shr_pat(cfg_shr_pat), .shr_mask(cfg_shr_mask),
    .byp_pat(cfg_byp_pat), .byp_mask(cfg_byp_mask), .byp_base(cfg_byp_base),
    .path(r_path), .eff_id(r_eff_id), .byp_rp(r_byp_rp)
  );

  pgx_hash #(.IDX_W(IDX_W)) u_req_hash (.id(r_eff_id), .vp(req_vp), .idx(r_idx));

  // write side classification
  path_e            w_path;
  logic [ID_W-1:0]  w_eff_id_unused;
  logic [RP_W-1:0]  w_byp_rp_unused;
  logic [IDX_W-1:0] w_idx;
  logic             w_ok;
  entry_t           w_entry;

  pgx_area_sel u_wr_sel (
    .id(wr_id), .vp(wr_vp),
    .shr_pat(cfg_shr_pat), .shr_mask(cfg_shr_mask),
    .byp_pat(cfg_byp_pat), .byp_mask(cfg_byp_mask), .byp_base(cfg_byp_base),
    .path(w_path), .eff_id(w_eff_id_unused), .byp_rp(w_byp_rp_unused)
  );

  pgx_hash #(.IDX_W(IDX_W)) u_wr_hash (.id(wr_id), .vp(wr_vp), .idx(w_idx));

  assign w_ok    = wr_en && !rst && (w_path != PATH_IDENT) && (w_path != PATH_BYPASS);
  assign w_entry = '{id: wr_id, vp: wr_vp, rp: wr_rp, flags: wr_flags};

  // handshake
  logic  rsp_valid_q, accept;
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = rsp_valid_q;

  // store
  logic   t_vld;
  entry_t t_entry;

  pgx_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_en(accept && !rst), .rd_idx(r_idx),
    .rd_vld(t_vld), .rd_entry(t_entry),
    .wr_en(w_ok), .wr_idx(w_idx), .wr_entry(w_entry), .wr_vld(wr_entry_valid)
  );

  // result stage context
  path_e           path_q;
  logic [ID_W-1:0] eff_id_q;
  logic [VP_W-1:0] vp_q;
  logic [RP_W-1:0] byp_rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      path_q      <= PATH_IDENT;
      eff_id_q    <= '0;
      vp_q        <= '0;
      byp_rp_q    <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      path_q      <= r_path;
      eff_id_q    <= r_eff_id;
      vp_q        <= req_vp;
      byp_rp_q    <= r_byp_rp;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  logic hit;
  assign hit = t_vld && (t_entry.id == eff_id_q) && (t_entry.vp == vp_q);

  always_comb begin
    rsp_rp    = '0;
    rsp_flags = '0;
    rsp_fault = 1'b0;
    unique case (path_q)
      PATH_IDENT: begin
        rsp_rp    = RP_W'(vp_q);
        rsp_flags = FIXED_FLAGS;
      end
      PATH_BYPASS: begin
        rsp_rp    = byp_rp_q;
        rsp_flags = FIXED_FLAGS;
      end
      default: begin
        if (hit) begin
          rsp_rp    = t_entry.rp;
          rsp_flags = t_entry.flags;
        end else begin
          rsp_fault = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker
  import pgx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ID_W-1:0]   req_id,
  input logic [VP_W-1:0]   req_vp,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [RP_W-1:0]   rsp_rp,
  input logic [FLAG_W-1:0] rsp_flags,
  input logic              rsp_fault,
  input logic [VP_W-1:0]   cfg_byp_pat,
  input logic [VP_W-1:0]   cfg_byp_mask
);
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> req_ready); // R1
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rp) && $stable(rsp_flags) && $stable(rsp_fault)); // R2
  AST_IDENT_PATH: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (&req_id) |=> rsp_rp == $past(req_vp) && rsp_flags == 4'b1100 && !rsp_fault); // R3
  AST_BYPASS_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !(&req_id) && ((req_vp & cfg_byp_mask) == cfg_byp_pat)
    |=> !rsp_fault && rsp_flags == 4'b1100); // R4
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_rp == '0 && rsp_flags == '0); // R7
endmodule

bind pgxlate_top pgx_checker chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_id(req_id), .req_vp(req_vp), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rp(rsp_rp), .rsp_flags(rsp_flags), .rsp_fault(rsp_fault),
  .cfg_byp_pat(cfg_byp_pat), .cfg_byp_mask(cfg_byp_mask)
);

// File: tb/pgxlate_top_tb_top.sv
`timescale 1ns/1ps
module pgxlate_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 0, rsp_ready = 1, wr_en = 0, wr_entry_valid = 0;
  logic [15:0] req_id = 0, wr_id = 0;
  logic [21:0] req_vp = 0, wr_vp = 0, wr_rp = 0;
  logic [3:0]  wr_flags = 0;
  logic [21:0] cfg_shr_pat = 22'h200000, cfg_shr_mask = 22'h200000;
  logic [21:0] cfg_byp_pat = 22'h300000, cfg_byp_mask = 22'h300000;
  logic [21:0] cfg_byp_base = 22'h1AB000;
  logic req_ready, rsp_valid, rsp_fault;
  logic [21:0] rsp_rp;
  logic [3:0]  rsp_flags;

  pgxlate_top dut_i (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  string scen = "R11";

  // reference model state
  bit          mv [256];
  logic [15:0] mid [256];
  logic [21:0] mvp [256], mrp [256];
  logic [3:0]  mfl [256];
  bit          m_rv = 0, m_stall = 0, m_ft = 0;
  logic [21:0] m_rp = 0;
  logic [3:0]  m_fl = 0;
  string       m_tag = "R1";

  function automatic int f_hash(logic [15:0] id, logic [21:0] vp);
    logic [37:0] key = {id, vp};
    int h = 0;
    for (int j = 0; j < 38; j++) if (key[j]) h = h ^ (1 << (j % 8));
    return h;
  endfunction

  function automatic bit f_in(logic [21:0] vp, logic [21:0] m, logic [21:0] p);
    return (vp & m) == p;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %h expected %h", tag, scen, what, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    chk(req_ready === (!m_rv || rsp_ready), "R1", "req_ready", req_ready, !m_rv || rsp_ready);
    chk(rsp_valid === m_rv, "R1", "rsp_valid", rsp_valid, m_rv);
    if (m_rv) begin
      t = m_stall ? "R2" : m_tag;
      chk(rsp_fault === m_ft, t, "fault", rsp_fault, m_ft);
      chk(rsp_rp === m_rp, t, "rp", rsp_rp, m_rp);
      chk(rsp_flags === m_fl, t, "flags", rsp_flags, m_fl);
    end
  endtask

  task automatic tick();
    bit nrv = m_rv, nft = m_ft, wok, stall_next;
    logic [21:0] nrp = m_rp;
    logic [3:0]  nfl = m_fl;
    logic [15:0] eid;
    string ntag = m_tag;
    int i;
    stall_next = 0;
    if (rst) nrv = 0;
    else if (req_valid && (!m_rv || rsp_ready)) begin
      nrv = 1; nft = 0; nfl = 4'b1100;
      if (req_id == 16'hFFFF) begin nrp = req_vp; ntag = "R3"; end
      else if (f_in(req_vp, cfg_byp_mask, cfg_byp_pat)) begin
        nrp = (cfg_byp_base & cfg_byp_mask) | (req_vp & ~cfg_byp_mask); ntag = "R4";
      end else begin
        eid  = f_in(req_vp, cfg_shr_mask, cfg_shr_pat) ? 16'h0 : req_id;
        ntag = (eid != req_id) ? "R5" : "R6";
        i = f_hash(eid, req_vp);
        if (mv[i] && mid[i] == eid && mvp[i] == req_vp) begin nrp = mrp[i]; nfl = mfl[i]; end
        else begin nrp = 0; nfl = 0; nft = 1; ntag = "R7"; end
      end
    end else if (rsp_ready) nrv = 0;
    else stall_next = m_rv;
    wok = !rst && wr_en && wr_id != 16'hFFFF && !f_in(wr_vp, cfg_byp_mask, cfg_byp_pat);
    i = f_hash(wr_id, wr_vp);
    @(posedge clk);
    if (rst) for (int k = 0; k < 256; k++) mv[k] = 0;
    else if (wok) begin
      mv[i] = wr_entry_valid; mid[i] = wr_id; mvp[i] = wr_vp; mrp[i] = wr_rp; mfl[i] = wr_flags;
    end
    m_rv = nrv; m_rp = nrp; m_fl = nfl; m_ft = nft; m_tag = ntag; m_stall = stall_next;
    @(negedge clk);
    compare();
  endtask

  task automatic lookup(logic [15:0] id, logic [21:0] vp);
    bit taken = 0;
    req_valid = 1; req_id = id; req_vp = vp;
    while (!taken) begin
      taken = !m_rv || rsp_ready;
      tick();
    end
    req_valid = 0;
    tick();
  endtask

  task automatic write(logic [15:0] id, logic [21:0] vp, logic [21:0] rp, logic [3:0] fl, bit v);
    wr_en = 1; wr_id = id; wr_vp = vp; wr_rp = rp; wr_flags = fl; wr_entry_valid = v;
    tick();
    wr_en = 0;
  endtask

  function automatic logic [21:0] find_coll(logic [15:0] id, int target, logic [21:0] avoid);
    for (int w = 1; w < 65536; w++)
      if (f_hash(id, 22'(w)) == target && 22'(w) != avoid) return 22'(w);
    return 22'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [21:0] va, vb;
    @(negedge clk);
    // R11: write during reset must be lost
    write(16'h0003, 22'h000100, 22'h012345, 4'hA, 1);
    tick(); tick();
    rst = 0;
    tick();
    lookup(16'h0003, 22'h000100);

    scen = "R6";
    write(16'h0003, 22'h000100, 22'h012345, 4'hA, 1);
    write(16'h0004, 22'h000ABC, 22'h03FFFF, 4'h7, 1);
    lookup(16'h0003, 22'h000100);
    lookup(16'h0004, 22'h000ABC);
    scen = "R7";
    lookup(16'h0005, 22'h000100);
    lookup(16'h0003, 22'h000101);

    scen = "R3";
    lookup(16'hFFFF, 22'h2ABCDE);
    lookup(16'hFFFF, 22'h000000);
    scen = "R4";
    lookup(16'h0009, 22'h3F0123);
    lookup(16'h0000, 22'h300000);

    scen = "R5";
    write(16'h0000, 22'h200040, 22'h055555, 4'h3, 1);
    lookup(16'h0007, 22'h200040);
    lookup(16'h0000, 22'h200040);
    write(16'h0007, 22'h200080, 22'h011111, 4'h1, 1);
    lookup(16'h0007, 22'h200080);

    scen = "R8";
    va = 22'h000100;
    vb = find_coll(16'h0003, f_hash(16'h0003, va), va);
    write(16'h0003, vb, 22'h000777, 4'h5, 1);
    lookup(16'h0003, vb);
    lookup(16'h0003, va);

    scen = "R9";
    write(16'h0003, vb, 22'h0, 4'h0, 0);
    lookup(16'h0003, vb);

    scen = "R10";
    write(16'h0002, 22'h000020, 22'h000222, 4'h6, 1);
    va = find_coll(16'hFFFF, f_hash(16'h0002, 22'h000020), 22'h0);
    write(16'hFFFF, va, 22'h0, 4'h0, 0);
    lookup(16'h0002, 22'h000020);
    write(16'h0002, 22'h300020, 22'h0, 4'h0, 0);
    lookup(16'h0002, 22'h000020);

    scen = "R12";
    write(16'h0006, 22'h000060, 22'h000111, 4'h2, 1);
    req_valid = 1; req_id = 16'h0006; req_vp = 22'h000060;
    wr_en = 1; wr_id = 16'h0006; wr_vp = 22'h000060; wr_rp = 22'h000999; wr_flags = 4'h9; wr_entry_valid = 1;
    tick();
    wr_en = 0; req_valid = 0;
    tick();
    lookup(16'h0006, 22'h000060);

    scen = "R2";
    rsp_ready = 0;
    req_valid = 1; req_id = 16'h0004; req_vp = 22'h000ABC;
    repeat (5) tick();
    rsp_ready = 1;
    tick(); tick();
    req_valid = 0;
    tick();

    scen = "R1";
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] ids [4] = '{16'h0, 16'h1, 16'h2, 16'hFFFF};
      req_valid = $urandom_range(0, 1);
      rsp_ready = ($urandom_range(0, 3) != 0);
      req_id = ids[$urandom_range(0, 3)];
      req_vp = {$urandom_range(0, 3) == 0 ? 2'b11 : 2'($urandom_range(0, 2)), 16'h0, 4'($urandom_range(0, 7))};
      wr_en = ($urandom_range(0, 3) == 0);
      wr_id = ids[$urandom_range(0, 3)];
      wr_vp = {2'($urandom_range(0, 3)), 16'h0, 4'($urandom_range(0, 7))};
      wr_rp = 22'($urandom);
      wr_flags = 4'($urandom);
      wr_entry_valid = ($urandom_range(0, 4) != 0);
      tick();
    end
    req_valid = 0; wr_en = 0; rsp_ready = 1;
    tick(); tick();

    scen = "R11";
    rst = 1;
    tick();
    rst = 0;
    lookup(16'h0004, 22'h000ABC);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule